// File: doc/BRIEF.md
# Serial Difference Quantizer with Reconstruction

This block turns the gap between an incoming audio sample and its prediction into a 4-bit sign-magnitude code. The magnitude is found by successive approximation against a supplied step size, one bit per clock. The same pass also accumulates the difference a decoder would rebuild from that code, and presents it as a 16-bit two's complement value. A surrounding adaptive coder feeds in the sample, its running prediction and the current step. It then uses the code as its compressed output and the rebuilt difference to update its prediction.

A bare 3-bit counter sequences the work. Each count value drives a fixed set of strobes into the datapath. The stages are, in order: capture of the difference, three magnitude decisions, sign correction of the rebuilt value, and loading of the results. A final count value signals completion. An operation takes eight counter states from start to idle.

Top module: `serial_quantizer`

## Requirements
- R1: While `rstN` is low and after its release, `busy` and `done` are 0 and `code` and `recon` read 0.
- R2: A `start` pulse seen while idle raises `busy` on the following cycle. `busy` stays high for exactly six cycles. Then `done` is 1 for exactly one cycle with `busy` low, and the block returns to idle on the next cycle.
- R3: `start` is ignored while `busy` is high and in the cycle where `done` is high. The sequence is neither restarted nor lengthened, and no extra `done` appears.
- R4: `code[3]` (the sign) is 1 exactly when `sample - pred`, evaluated without wrap-around, is negative. A zero difference gives sign 0.
- R5: `code[2:0]` = {b2,b1,b0} are decided in the order b2, b1, b0. They use thresholds `step`, `step>>1`, `step>>2` against the remaining magnitude |sample-pred|. A bit is 1 when the remainder is at least the threshold, and in that case the threshold is removed from the remainder.
- R6: `recon` equals `(step>>3)` plus each threshold whose bit was 1. The result is negated when the sign bit is 1.
- R7: When the rebuilt value falls outside the 16-bit range, `recon` saturates to 32767 or -32768.
- R8: `code` and `recon` change only in the cycle before `done` goes high. They hold their values while idle, even when `sample`, `pred` or `step` change.
- R9: Differences at the extremes of the input range (for example 32767 - (-32768)) are quantized correctly, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one quantization; acted on only when idle |
| sample | input | 16 | Input sample, two's complement; hold until `done` |
| pred | input | 16 | Predicted sample, two's complement; hold until `done` |
| step | input | 15 | Quantizer step size, unsigned; hold until `done` |
| code | output | 4 | Sign-magnitude code {sign, b2, b1, b0} |
| recon | output | 16 | Reconstructed difference, two's complement |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when results are ready |

## Verification
The bench targets the following corner cases:
- A step of zero: every magnitude bit must come out 1 with a zero rebuild. A design that compares with strict inequality yields 000.
- A zero difference: the sign must stay positive and the rebuild must be exactly `step>>3`.
- The widest differences and the largest step: a design that sizes its subtractor or accumulator to 16 bits wraps around and flips the sign, or produces a wrong magnitude, where it should saturate.
- `start` pulses injected during the busy window and on the `done` cycle, plus idle input changes after completion: a design that re-arms early or reloads its outputs outside the publish stage shifts the `done` pulse or corrupts the held results.

// File: rtl/qz_pkg.sv
package qz_pkg;

  // Strobes from the sequencer to the datapath, one per stage kind.
  typedef struct packed {
    logic capture;  // latch sign, magnitude, threshold, seed
    logic decide;   // resolve one magnitude bit
    logic negate;   // apply sign to rebuilt value
    logic publish;  // move results to output registers
  } qzStrobe_t;

  localparam int unsigned SEQ_W = 3;

endpackage

// File: rtl/qz_ctrl.sv
module qz_ctrl
  import qz_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output qzStrobe_t ctl,
  output logic      busy,
  output logic      done
);

  localparam logic [SEQ_W-1:0] ST_IDLE = '0;
  localparam logic [SEQ_W-1:0] ST_CAPT = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] ST_BIT0 = SEQ_W'(2);
  localparam logic [SEQ_W-1:0] ST_BIT2 = SEQ_W'(4);
  localparam logic [SEQ_W-1:0] ST_NEG  = SEQ_W'(5);
  localparam logic [SEQ_W-1:0] ST_PUB  = SEQ_W'(6);
  localparam logic [SEQ_W-1:0] ST_DONE = '1;

  logic [SEQ_W-1:0] stateQ;

  // Linear count: idle waits for start, all others step unconditionally.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   stateQ <= ST_IDLE;
    else if (stateQ != ST_IDLE || start)         stateQ <= stateQ + SEQ_W'(1);
  end

  // Fixed control word per count value.
  always_comb begin
    ctl.capture = (stateQ == ST_CAPT);
    ctl.decide  = (stateQ >= ST_BIT0) && (stateQ <= ST_BIT2);
    ctl.negate  = (stateQ == ST_NEG);
    ctl.publish = (stateQ == ST_PUB);
    busy        = (stateQ != ST_IDLE) && (stateQ != ST_DONE);
    done        = (stateQ == ST_DONE);
  end

  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |=> (stateQ == SEQ_W'($past(stateQ) + SEQ_W'(1))));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start) |=> busy);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !start) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/qz_datapath.sv
module qz_datapath
  import qz_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 15
)(
  input  logic              clk,
  input  logic              rstN,
  input  qzStrobe_t         ctl,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pred,
  input  logic [STEP_W-1:0] step,
  output logic [3:0]        code,
  output logic [DATA_W-1:0] recon
);

  localparam int unsigned MAG_W = DATA_W + 1;
  localparam int unsigned ACC_W = ((STEP_W + 1 > DATA_W) ? STEP_W + 1 : DATA_W) + 2;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(1 << (DATA_W - 1));

  logic                    signQ;
  logic [MAG_W-1:0]        magQ;
  logic [STEP_W-1:0]       thrQ;
  logic signed [ACC_W-1:0] accQ;
  logic [2:0]              bitsQ;
  logic [3:0]              codeQ;
  logic [DATA_W-1:0]       reconQ;

  logic signed [MAG_W-1:0] diff;
  logic [MAG_W-1:0]        thrWide;
  logic                    hit;
  logic [DATA_W-1:0]       satAcc;

  always_comb begin
    diff    = $signed({sample[DATA_W-1], sample}) - $signed({pred[DATA_W-1], pred});
    thrWide = MAG_W'(thrQ);
    hit     = (magQ >= thrWide);
    if (accQ > POS_LIM)      satAcc = POS_LIM[DATA_W-1:0];
    else if (accQ < NEG_LIM) satAcc = NEG_LIM[DATA_W-1:0];
    else                     satAcc = accQ[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signQ  <= 1'b0;
      magQ   <= '0;
      thrQ   <= '0;
      accQ   <= '0;
      bitsQ  <= '0;
      codeQ  <= '0;
      reconQ <= '0;
    end else begin
      if (ctl.capture) begin
        signQ <= diff[MAG_W-1];
        magQ  <= diff[MAG_W-1] ? MAG_W'(-diff) : MAG_W'(diff);
        thrQ  <= step;
        accQ  <= ACC_W'(step >> 3);
        bitsQ <= '0;
      end
      if (ctl.decide) begin
        bitsQ <= {bitsQ[1:0], hit};
        thrQ  <= thrQ >> 1;
        if (hit) begin
          magQ <= magQ - thrWide;
          accQ <= accQ + ACC_W'(thrQ);
        end
      end
      if (ctl.negate && signQ) accQ <= -accQ;
      if (ctl.publish) begin
        codeQ  <= {signQ, bitsQ};
        reconQ <= satAcc;
      end
    end
  end

  assign code  = codeQ;
  assign recon = reconQ;

  a_r5_mag_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decide |=> (magQ <= $past(magQ)));

  a_r6_sign_agrees: assert property (@(posedge clk) disable iff (!rstN)
    ctl.publish |=> !(!codeQ[3] && reconQ[DATA_W-1]));

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.publish |=> ($stable(codeQ) && $stable(reconQ)));

  a_r7_saturated_range: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.publish && (accQ > POS_LIM)) |=> (reconQ == POS_LIM[DATA_W-1:0]));

endmodule

// File: rtl/serial_quantizer.sv
module serial_quantizer
  import qz_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 15
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pred,
  input  logic [STEP_W-1:0] step,
  output logic [3:0]        code,
  output logic [DATA_W-1:0] recon,
  output logic              busy,
  output logic              done
);

  qzStrobe_t ctl;

  qz_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  qz_datapath #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .sample (sample),
    .pred   (pred),
    .step   (step),
    .code   (code),
    .recon  (recon)
  );

endmodule

// File: tb/sim_serial_quantizer.sv
module sim_serial_quantizer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] sample = '0;
  logic [15:0] pred = '0;
  logic [14:0] step = '0;
  logic [3:0]  code;
  logic [15:0] recon;
  logic        busy;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [19:0] expQ[$];
  logic [19:0] lastExp = '0;

  always #10 clk = ~clk;  // 50 MHz

  serial_quantizer u0 (
    .clk(clk), .rstN(rstN), .start(start), .sample(sample), .pred(pred),
    .step(step), .code(code), .recon(recon), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent model of R4..R7: returns {code, recon}.
  function automatic logic [19:0] model(input logic [15:0] s, input logic [15:0] p,
                                        input logic [14:0] st);
    int d, m, thr, acc;
    logic [2:0] b;
    bit neg;
    d   = int'($signed(s)) - int'($signed(p));
    neg = (d < 0);
    m   = neg ? -d : d;
    thr = int'(st);
    acc = thr >> 3;
    b   = '0;
    for (int k = 0; k < 3; k++) begin
      b = b << 1;
      if (m >= thr) begin
        b[0] = 1'b1;
        m    = m - thr;
        acc  = acc + thr;
      end
      thr = thr >> 1;
    end
    if (neg) acc = -acc;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return {neg, b, 16'(acc)};
  endfunction

  // Driver: one operation, checks the busy/done timeline (R2) and
  // optionally pokes start during busy and on the done cycle (R3).
  task automatic runOp(input logic [15:0] s, input logic [15:0] p,
                       input logic [14:0] st, input bit poke);
    @(negedge clk);
    sample = s; pred = p; step = st; start = 1'b1;
    expQ.push_back(model(s, p, st));
    lastExp = model(s, p, st);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      start = (poke && k == 3);
      check(busy === 1'b1, poke ? "R3" : "R2", "busy during op", int'(busy), 1);
      check(done === 1'b0, poke ? "R3" : "R2", "done early", int'(done), 0);
    end
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R2", "done cycle {done,busy}",
          int'({done, busy}), 2);
    start = poke;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0 && busy === 1'b0, poke ? "R3" : "R2", "idle after done {done,busy}",
          int'({done, busy}), 0);
  endtask

  // Monitor: pops the scoreboard whenever done is seen.
  always @(negedge clk) begin
    if (rstN && done === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected done, queue empty", 1, 0);
      end else begin
        logic [19:0] e;
        e = expQ.pop_front();
        check(code[3] === e[19], "R4", "sign bit", int'(code[3]), int'(e[19]));
        check(code[2:0] === e[18:16], "R5", "magnitude bits", int'(code[2:0]), int'(e[18:16]));
        check(recon === e[15:0], "R6/R7", "recon", int'($signed(recon)), int'($signed(e[15:0])));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", int'({busy, done}), 0);
    check(code === 4'd0 && recon === 16'd0, "R1", "outputs in reset", int'(recon), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && code === 4'd0, "R1", "after release",
          int'({busy, done, code}), 0);

    runOp(16'd1000, 16'd400, 15'd256, 1'b0);       // R5: 600 vs 256 -> 111
    runOp(16'd400, 16'd1000, 15'd256, 1'b0);       // R4: negative difference
    runOp(16'd500, 16'd500, 15'd100, 1'b0);        // R4: zero diff, sign 0, recon step>>3
    runOp(16'd77, 16'd10, 15'd0, 1'b0);            // R5: zero step -> all ones
    runOp(16'd300, 16'd100, 15'd160, 1'b1);        // R3: start pokes ignored
    runOp(16'h7FFF, 16'h8000, 15'h7FFF, 1'b0);     // R7 R9: saturate positive
    runOp(16'h8000, 16'h7FFF, 15'h7FFF, 1'b0);     // R7 R9: saturate negative
    runOp(16'h8000, 16'h7FFF, 15'd4096, 1'b0);     // R9: wide negative difference
    runOp(16'd150, 16'd0, 15'd200, 1'b0);          // R5: 150 vs 200,100,50 -> 011

    // R8: outputs hold while idle inputs move.
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sample = 16'(k * 1234); pred = 16'(k * 77); step = 15'(k * 999);
      check(code === lastExp[19:16], "R8", "code held", int'(code), int'(lastExp[19:16]));
      check(recon === lastExp[15:0], "R8", "recon held", int'(recon), int'(lastExp[15:0]));
    end

    for (int i = 0; i < 60; i++) begin
      runOp(16'($urandom), 16'($urandom), 15'($urandom), (i % 7) == 0);
    end

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2", "results left unobserved", expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule